// File: doc/BRIEF.md
# Dual-Domain Reset Sequencer

This block turns one external asynchronous reset into two local resets, one for a slow clock domain (about 100 MHz) and one for a fast, unrelated clock domain (about 270 MHz). Both local resets go active the moment the external reset goes high, with no clock needed. Each one is released only on a rising edge of its own clock, so every flip-flop in a domain leaves reset on the same edge.

The fast reset is also held back until the slow domain has shown that it was clocked while still in reset. A flag set in the slow domain records this. The flag reaches the fast domain through a two-flop synchronizer, and only then can the fast release chain start. The fast logic therefore cannot start before the slow logic has been cleared.

The block also carries single-bit control signals across the boundary in both directions. Each bit passes through a two-flop synchronizer in the destination domain, and that synchronizer is held cleared by the destination domain's reset.

Top module: `rstseq_top`

## Requirements
- R1: Both `rstSlow` and `rstFast` go to 1 in the same time step in which `extRst` rises, without any clock edge.
- R2: While `extRst` is 1, both reset outputs stay at 1, whatever the clocks do.
- R3: With the default two-stage release chain, `rstSlow` falls exactly on the second rising edge of `clkSlow` that comes strictly after `extRst` falls.
- R4: `rstFast` falls exactly on the fourth rising edge of `clkFast` that comes strictly after the first `clkSlow` rising edge following the fall of `extRst`. This is two synchronizer stages plus two release stages. The fast reset is never released unless the slow domain has been clocked with its reset active.
- R5: When the clocks run at 100 MHz and 270 MHz, `rstFast` never falls while `rstSlow` is still 1.
- R6: If `extRst` rises again before a release has happened, that release does not happen. The sequence then restarts in full from the next fall of `extRst`.
- R7: A change on bit b of `ctlToFastIn` appears on bit b of `ctlToFastOut` at the second `clkFast` rising edge after the change.
- R8: A change on bit b of `ctlToSlowIn` appears on bit b of `ctlToSlowOut` at the second `clkSlow` rising edge after the change.
- R9: While a domain's reset output is 1, that domain's synchronized control outputs read 0.
- R10: Once released, a reset output stays 0 until `extRst` rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkSlow | input | 1 | Slow-domain clock |
| clkFast | input | 1 | Fast-domain clock, no phase relation to clkSlow |
| extRst | input | 1 | External asynchronous reset, active high |
| ctlToFastIn | input | CTL_BITS | Control bits launched in the slow domain |
| ctlToSlowIn | input | CTL_BITS | Control bits launched in the fast domain |
| rstSlow | output | 1 | Slow-domain reset, active high |
| rstFast | output | 1 | Fast-domain reset, active high |
| ctlToFastOut | output | CTL_BITS | ctlToFastIn synchronized to clkFast |
| ctlToSlowOut | output | CTL_BITS | ctlToSlowIn synchronized to clkSlow |

## Verification
The hardest case to reach is a reset that comes back while the release sequence is only part done. In that case the slow-seen flag may already be set, or partly synchronized into the fast domain, when the chains are cleared again. The stimulus alternates long release windows with short ones of under 3 ns, placed at random phases of both clocks. It keeps every edge of the reset off any clock edge, so the exact edge on which each release is due can be computed from the clock periods. A release that shows up in a short window, or at any edge other than the expected one, is reported.

// File: rtl/rstseq_pkg.sv
`timescale 1ps/1ps
package rstseq_pkg;
  // Reset strobes handed from the sequencing control to the crossing datapath.
  typedef struct packed {
    logic rstSlow;
    logic rstFast;
  } rst_strobes_t;
endpackage

// File: rtl/rstseq_sync.sv
`timescale 1ps/1ps
// Generic flop chain with asynchronous preset/clear; also used as a reset release chain.
module rstseq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) chain <= {STAGES{RST_VAL}};
    else      chain <= {chain[LAST-1:0], d};
  end

  assign q = chain[LAST];
endmodule

// File: rtl/rstseq_ctrl.sv
`timescale 1ps/1ps
// Reset sequencing: slow domain releases first, fast domain waits for proof of a slow clocked reset.
module rstseq_ctrl
  import rstseq_pkg::*;
#(
  parameter int RST_STAGES  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clkSlow,
  input  logic         clkFast,
  input  logic         extRst,
  output rst_strobes_t strobes,
  output logic         slowSeen
);
  logic slowRstQ;
  logic seenInFast;
  logic fastRstQ;

  // Slow release chain: preset to 1, shifts in 0.
  rstseq_sync #(.STAGES(RST_STAGES), .RST_VAL(1'b1)) slowChain_i (
    .clk (clkSlow),
    .arst(extRst),
    .d   (1'b0),
    .q   (slowRstQ)
  );

  // Set on a slow edge at which the slow domain is still held in reset.
  always_ff @(posedge clkSlow or posedge extRst) begin
    if (extRst)        slowSeen <= 1'b0;
    else if (slowRstQ) slowSeen <= 1'b1;
  end

  rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) seenSync_i (
    .clk (clkFast),
    .arst(extRst),
    .d   (slowSeen),
    .q   (seenInFast)
  );

  // Fast release chain: only starts shifting 0 once the flag has crossed.
  rstseq_sync #(.STAGES(RST_STAGES), .RST_VAL(1'b1)) fastChain_i (
    .clk (clkFast),
    .arst(extRst),
    .d   (~seenInFast),
    .q   (fastRstQ)
  );

  assign strobes.rstSlow = slowRstQ;
  assign strobes.rstFast = fastRstQ;
endmodule

// File: rtl/rstseq_xing.sv
`timescale 1ps/1ps
// Control-bit crossings, each bit synchronized in its destination domain.
module rstseq_xing
  import rstseq_pkg::*;
#(
  parameter int CTL_BITS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clkSlow,
  input  logic                clkFast,
  input  rst_strobes_t        strobes,
  input  logic [CTL_BITS-1:0] ctlToFastIn,
  input  logic [CTL_BITS-1:0] ctlToSlowIn,
  output logic [CTL_BITS-1:0] ctlToFastOut,
  output logic [CTL_BITS-1:0] ctlToSlowOut
);
  for (genvar b = 0; b < CTL_BITS; b++) begin : g_bit
    rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) toFast_i (
      .clk (clkFast),
      .arst(strobes.rstFast),
      .d   (ctlToFastIn[b]),
      .q   (ctlToFastOut[b])
    );
    rstseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) toSlow_i (
      .clk (clkSlow),
      .arst(strobes.rstSlow),
      .d   (ctlToSlowIn[b]),
      .q   (ctlToSlowOut[b])
    );
  end
endmodule

// File: rtl/rstseq_top.sv
`timescale 1ps/1ps
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int RST_STAGES  = 2,
  parameter int SYNC_STAGES = 2,
  parameter int CTL_BITS    = 2
) (
  input  logic                clkSlow,
  input  logic                clkFast,
  input  logic                extRst,
  input  logic [CTL_BITS-1:0] ctlToFastIn,
  input  logic [CTL_BITS-1:0] ctlToSlowIn,
  output logic                rstSlow,
  output logic                rstFast,
  output logic [CTL_BITS-1:0] ctlToFastOut,
  output logic [CTL_BITS-1:0] ctlToSlowOut
);
  rst_strobes_t strobes;
  logic         slowSeen;

  rstseq_ctrl #(.RST_STAGES(RST_STAGES), .SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clkSlow (clkSlow),
    .clkFast (clkFast),
    .extRst  (extRst),
    .strobes (strobes),
    .slowSeen(slowSeen)
  );

  rstseq_xing #(.CTL_BITS(CTL_BITS), .SYNC_STAGES(SYNC_STAGES)) xing_i (
    .clkSlow     (clkSlow),
    .clkFast     (clkFast),
    .strobes     (strobes),
    .ctlToFastIn (ctlToFastIn),
    .ctlToSlowIn (ctlToSlowIn),
    .ctlToFastOut(ctlToFastOut),
    .ctlToSlowOut(ctlToSlowOut)
  );

  assign rstSlow = strobes.rstSlow;
  assign rstFast = strobes.rstFast;
endmodule

// File: rtl/rstseq_chk.sv
`timescale 1ps/1ps
module rstseq_chk #(
  parameter int CTL_BITS = 2
) (
  input logic                clkSlow,
  input logic                clkFast,
  input logic                extRst,
  input logic                rstSlow,
  input logic                rstFast,
  input logic                slowSeen,
  input logic [CTL_BITS-1:0] ctlToFastOut,
  input logic [CTL_BITS-1:0] ctlToSlowOut
);
  // R1 / R2: reset outputs held while the external reset is high
  a_r2_slow_held: assert property (@(posedge clkSlow) extRst |-> rstSlow);
  a_r2_fast_held: assert property (@(posedge clkFast) extRst |-> rstFast);

  // R3: slow release only after a slow edge that already saw the reset low
  a_r3_slow_release: assert property (@(posedge clkSlow) disable iff (extRst)
    $fell(rstSlow) |-> (!$past(extRst) && slowSeen));

  // R4: fast release needs the slow-seen flag
  a_r4_fast_gate: assert property (@(posedge clkFast) disable iff (extRst)
    $fell(rstFast) |-> slowSeen);

  // R5: slow domain is out of reset whenever the fast domain is
  a_r5_order: assert property (@(posedge clkFast) disable iff (extRst)
    !rstFast |-> !rstSlow);

  // R9: synchronized control outputs quiet during their domain's reset
  a_r9_fast_quiet: assert property (@(posedge clkFast) rstFast |-> (ctlToFastOut == '0));
  a_r9_slow_quiet: assert property (@(posedge clkSlow) rstSlow |-> (ctlToSlowOut == '0));

  // R10: a released reset stays released until the external reset returns
  a_r10_slow_stays: assert property (@(posedge clkSlow) disable iff (extRst)
    !rstSlow |=> !rstSlow);
  a_r10_fast_stays: assert property (@(posedge clkFast) disable iff (extRst)
    !rstFast |=> !rstFast);
endmodule

bind rstseq_top rstseq_chk #(.CTL_BITS(CTL_BITS)) chk_i (
  .clkSlow     (clkSlow),
  .clkFast     (clkFast),
  .extRst      (extRst),
  .rstSlow     (rstSlow),
  .rstFast     (rstFast),
  .slowSeen    (slowSeen),
  .ctlToFastOut(ctlToFastOut),
  .ctlToSlowOut(ctlToSlowOut)
);

// File: tb/rstseq_top_tb_top.sv
`timescale 1ps/1ps
module rstseq_top_tb_top;
  localparam longint SLOW_PERIOD = 10000;
  localparam longint FAST_PERIOD = 3700;
  localparam longint SLOW_HALF   = SLOW_PERIOD / 2;
  localparam longint FAST_HALF   = FAST_PERIOD / 2;
  localparam int     CTL_BITS    = 2;

  logic                clkSlow = 1'b0;
  logic                clkFast = 1'b0;
  logic                extRst  = 1'b0;
  logic [CTL_BITS-1:0] ctlToFastIn = '0;
  logic [CTL_BITS-1:0] ctlToSlowIn = '0;
  logic                rstSlow, rstFast;
  logic [CTL_BITS-1:0] ctlToFastOut, ctlToSlowOut;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  ctlWatch = 1'b0;
  bit  finished = 1'b0;

  longint qSlow[$];
  longint qFast[$];
  longint qCfT[$];
  longint qCfV[$];
  longint qCsT[$];
  longint qCsV[$];

  always #(SLOW_HALF) clkSlow = ~clkSlow;
  always #(FAST_HALF) clkFast = ~clkFast;

  rstseq_top #(.CTL_BITS(CTL_BITS)) dut_i (
    .clkSlow     (clkSlow),
    .clkFast     (clkFast),
    .extRst      (extRst),
    .ctlToFastIn (ctlToFastIn),
    .ctlToSlowIn (ctlToSlowIn),
    .rstSlow     (rstSlow),
    .rstFast     (rstFast),
    .ctlToFastOut(ctlToFastOut),
    .ctlToSlowOut(ctlToSlowOut)
  );

  // First rising edge strictly after t for a clock starting low at time zero.
  function automatic longint nextEdge(input longint t, input longint half);
    longint e;
    e = (t / (2 * half)) * (2 * half) + half;
    if (e <= t) e = e + 2 * half;
    return e;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- monitors ----------------
  always @(negedge rstSlow) begin
    if (qSlow.size() == 0) check("R6 unexpected slow release", $time, -1);
    else check("R3 slow release time", $time, qSlow.pop_front());
  end

  always @(negedge rstFast) begin
    if (qFast.size() == 0) check("R6 unexpected fast release", $time, -1);
    else check("R4 fast release time", $time, qFast.pop_front());
    check("R5 slow released first", longint'(rstSlow), 0);
  end

  always @(ctlToFastOut) begin
    if (ctlWatch) begin
      if (qCfT.size() == 0) check("R7 unexpected fast ctl change", $time, -1);
      else begin
        check("R7 fast ctl time", $time, qCfT.pop_front());
        check("R7 fast ctl value", longint'(ctlToFastOut), qCfV.pop_front());
      end
    end
  end

  always @(ctlToSlowOut) begin
    if (ctlWatch) begin
      if (qCsT.size() == 0) check("R8 unexpected slow ctl change", $time, -1);
      else begin
        check("R8 slow ctl time", $time, qCsT.pop_front());
        check("R8 slow ctl value", longint'(ctlToSlowOut), qCsV.pop_front());
      end
    end
  end

  // ---------------- driver ----------------
  // All stimulus lands 25 ps past a 50 ps grid; every clock edge sits on the grid.
  task automatic releaseWindow(input longint lowPs, input bit expectRelease);
    longint tRel, s1;
    extRst = 1'b0;
    tRel = $time;
    if (expectRelease) begin
      s1 = nextEdge(tRel, SLOW_HALF);
      qSlow.push_back(s1 + SLOW_PERIOD);
      qFast.push_back(nextEdge(s1, FAST_HALF) + 3 * FAST_PERIOD);
    end
    #(lowPs);
    extRst = 1'b1;
    #1;
    check("R1 slow asserted at once", longint'(rstSlow), 1);
    check("R1 fast asserted at once", longint'(rstFast), 1);
    #49;
  endtask

  task automatic holdReset(input longint holdPs);
    #(holdPs);
    check("R2 slow held", longint'(rstSlow), 1);
    check("R2 fast held", longint'(rstFast), 1);
  endtask

  task automatic driveToFast(input logic [CTL_BITS-1:0] v);
    ctlToFastIn = v;
    qCfT.push_back(nextEdge($time, FAST_HALF) + FAST_PERIOD);
    qCfV.push_back(longint'(v));
    #(30000);
  endtask

  task automatic driveToSlow(input logic [CTL_BITS-1:0] v);
    ctlToSlowIn = v;
    qCsT.push_back(nextEdge($time, SLOW_HALF) + SLOW_PERIOD);
    qCsV.push_back(longint'(v));
    #(40000);
  endtask

  initial begin
    extRst = 1'b1;
    #25;
    #(20000);
    check("R2 reset state slow", longint'(rstSlow), 1);
    check("R2 reset state fast", longint'(rstFast), 1);
    check("R9 reset state ctl fast", longint'(ctlToFastOut), 0);
    check("R9 reset state ctl slow", longint'(ctlToSlowOut), 0);

    for (int i = 0; i < 10; i++) begin
      // Short window: no release may happen (R6).
      releaseWindow(longint'($urandom_range(1, 59)) * 50, 1'b0);
      holdReset(longint'($urandom_range(0, 200)) * 50 + 12000);
      // Long window at a random phase: full release expected.
      releaseWindow(longint'($urandom_range(0, 400)) * 50 + 40000, 1'b1);
      holdReset(longint'($urandom_range(0, 200)) * 50 + 12000);
    end

    // Final release, then control crossings.
    extRst = 1'b0;
    begin
      longint s1;
      s1 = nextEdge($time, SLOW_HALF);
      qSlow.push_back(s1 + SLOW_PERIOD);
      qFast.push_back(nextEdge(s1, FAST_HALF) + 3 * FAST_PERIOD);
    end
    #(60000);
    check("R10 slow stays released", longint'(rstSlow), 0);
    check("R10 fast stays released", longint'(rstFast), 0);

    ctlWatch = 1'b1;
    driveToFast(2'b01);
    #(longint'($urandom_range(0, 70)) * 50);
    driveToFast(2'b11);
    driveToFast(2'b10);
    #(longint'($urandom_range(0, 70)) * 50);
    driveToFast(2'b00);
    driveToSlow(2'b10);
    #(longint'($urandom_range(0, 190)) * 50);
    driveToSlow(2'b11);
    driveToSlow(2'b01);
    driveToSlow(2'b00);
    ctlWatch = 1'b0;

    // R9: control outputs cleared by the domain reset even with inputs high.
    ctlToFastIn = '1;
    ctlToSlowIn = '1;
    #(40000);
    check("R7 fast ctl high before reset", longint'(ctlToFastOut), 3);
    check("R8 slow ctl high before reset", longint'(ctlToSlowOut), 3);
    extRst = 1'b1;
    #(20000);
    check("R9 fast ctl cleared in reset", longint'(ctlToFastOut), 0);
    check("R9 slow ctl cleared in reset", longint'(ctlToSlowOut), 0);
    ctlToFastIn = '0;
    ctlToSlowIn = '0;
    releaseWindow(60000, 1'b1);

    #(20000);
    check("R3 no pending slow release", longint'(qSlow.size()), 0);
    check("R4 no pending fast release", longint'(qFast.size()), 0);
    check("R7 no pending fast ctl", longint'(qCfT.size()), 0);
    check("R8 no pending slow ctl", longint'(qCsT.size()), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(400_000_000);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule